// File: doc/BRIEF.md
# Serial Conversion Result Readout Port

This block is the host-facing output port of a two-channel converter's digital side. A host pulls the active-low `start_n` input low to begin a conversion cycle. The port then drives its serial data line low to show that the converter is busy. It captures the 15-bit result of the channel that `chan_sel` named when the cycle began. After a programmable settle delay it raises the data line as a ready flag. The host then clocks the word out with `sclk`: the line updates on falling edges, most significant bit first. A host that samples on rising edges reads sixteen bits: a leading 1, the ready marker, and then the fifteen result bits.

`start_n` and `sclk` are asynchronous to the internal clock. Each passes through a two-flop synchroniser, and edges are detected after synchronisation. The conversion engine is modelled as a one-cycle `res_vld` strobe with two result buses. The tri-state data line is presented as a data bit plus an output enable.

A cycle ends when the host raises `start_n`. If all sixteen falling edges have arrived, the line releases at once. If not, the cycle is abandoned: the line stays driven low for three more internal cycles, then releases.

States and transitions:
- IDLE: line released. It moves to BUSY on a synchronised falling edge of `start_n`.
- BUSY: line low. On `res_vld` it moves to SETTLE, or to XFER when `dly_cfg` is 0. On a rise of `start_n` it moves to ABORT.
- SETTLE: line low for `dly_cfg` cycles, then XFER. On a rise of `start_n` it moves to ABORT.
- XFER: shifts the word out. On a rise of `start_n` it moves to IDLE if the transfer completed, otherwise to ABORT.
- ABORT: line low for 3 cycles, then IDLE.

Top module: `cvt_readout`

## Requirements
- R1: After reset `sdat_oe` is 0, which means the line is high impedance.
- R2: A synchronised falling edge of `start_n` seen in IDLE makes `sdat_oe` 1 and `sdat_o` 0, which signals busy.
- R3: `chan_sel` is sampled when the cycle starts: 0 selects `res_ch1` and 1 selects `res_ch2`. Changing it later in the cycle has no effect on the word sent.
- R4: The result is captured on the first `res_vld` seen in BUSY. A `res_vld` pulse during a transfer leaves the word unchanged.
- R5: `sdat_o` rises exactly `dly_cfg`+1 clock edges after the edge that samples `res_vld`, counting that edge as the first.
- R6: The first bit a rising-edge receiver samples is 1, which is the ready marker.
- R7: Each synchronised falling edge of `sclk` in XFER advances the line by one bit, so that the 15 result bits follow the marker MSB first. Falling edges beyond the sixteenth are ignored.
- R8: If `start_n` rises after sixteen falling edges, `sdat_oe` drops on the clock edge that acts on the synchronised rise.
- R9: If `start_n` rises in BUSY or SETTLE, or in XFER before sixteen falling edges, `sdat_oe` stays 1 for exactly 3 further cycles and then drops.
- R10: Falling edges of `sclk` in BUSY do not shift the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Active-low convert start, asynchronous |
| sclk | input | 1 | Serial readout clock, asynchronous |
| chan_sel | input | 1 | Channel select: 0 for channel 1, 1 for channel 2 |
| dly_cfg | input | DLY_W | Busy-to-ready settle delay in clock cycles |
| res_vld | input | 1 | One-cycle strobe: results are valid |
| res_ch1 | input | RES_W | Channel 1 result |
| res_ch2 | input | RES_W | Channel 2 result |
| sdat_o | output | 1 | Serial data value |
| sdat_oe | output | 1 | Serial data drive enable (0 means high impedance) |

## Verification
The hardest situations to reach are the abort paths, because each one needs `start_n` to rise at a chosen point in a half-finished cycle. The bench reaches them by stopping its stimulus partway: it raises `start_n` while still waiting for `res_vld`, and again after only five `sclk` pulses. It then counts the cycles until `sdat_oe` drops. It also inserts stray `sclk` pulses, a late `res_vld` and a late flip of `chan_sel` into otherwise normal cycles, then reads the whole word back through the port.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_SETTLE,
        ST_XFER,
        ST_ABORT
    } rd_state_e;

    localparam int ABORT_CYC = 3;

endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
    parameter int              W       = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                hold_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                hold_q <= meta_q;
            end
        end
        assign q[i] = hold_q;
    end

endmodule

// File: rtl/cvt_countdown.sv
module cvt_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && !load && zero_o)); // R9

endmodule

// File: rtl/cvt_shreg.sv
module cvt_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb_o
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[W-1];

    AST_SHIFT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (msb_o == $past(sh_q[W-2]))); // R7

    AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (msb_o == $past(load_val[W-1]))); // R6

endmodule

// File: rtl/cvt_readout.sv
module cvt_readout
    import cvt_pkg::*;
#(
    parameter int RES_W = 15,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic             sclk,
    input  logic             chan_sel,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic             res_vld,
    input  logic [RES_W-1:0] res_ch1,
    input  logic [RES_W-1:0] res_ch2,
    output logic             sdat_o,
    output logic             sdat_oe
);

    localparam int XW   = RES_W + 1;
    localparam int FC_W = $clog2(XW + 1);

    rd_state_e        state_q, state_d;
    logic [2:0]       sync_out;
    logic             start_s, sclk_s, chan_s;
    logic             start_prev_q, sclk_prev_q;
    logic             start_fall, start_rise, sclk_fall;
    logic             chan_q;
    logic [FC_W-1:0]  fall_cnt_q;
    logic             xfer_done;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [DLY_W-1:0] cnt_val;
    logic             sh_load, sh_shift, sh_msb;
    logic [RES_W-1:0] cap_res;

    cvt_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({chan_sel, sclk, start_n}),
        .q     (sync_out)
    );

    assign start_s = sync_out[0];
    assign sclk_s  = sync_out[1];
    assign chan_s  = sync_out[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_prev_q <= 1'b1;
            sclk_prev_q  <= 1'b0;
        end else begin
            start_prev_q <= start_s;
            sclk_prev_q  <= sclk_s;
        end
    end

    assign start_fall = start_prev_q && !start_s;
    assign start_rise = !start_prev_q && start_s;
    assign sclk_fall  = sclk_prev_q && !sclk_s;
    assign xfer_done  = (fall_cnt_q == FC_W'(XW));
    assign cap_res    = chan_q ? res_ch2 : res_ch1;

    cvt_countdown #(.W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero_o   (cnt_zero)
    );

    cvt_shreg #(.W(XW)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ({1'b1, cap_res}),
        .shift    (sh_shift),
        .msb_o    (sh_msb)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_fall) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (start_rise) begin
                    state_d  = ST_ABORT;
                    cnt_load = 1'b1;
                    cnt_val  = DLY_W'(ABORT_CYC - 1);
                end else if (res_vld) begin
                    sh_load = 1'b1;
                    if (dly_cfg == '0) begin
                        state_d = ST_XFER;
                    end else begin
                        state_d  = ST_SETTLE;
                        cnt_load = 1'b1;
                        cnt_val  = dly_cfg - DLY_W'(1);
                    end
                end
            end
            ST_SETTLE: begin
                if (start_rise) begin
                    state_d  = ST_ABORT;
                    cnt_load = 1'b1;
                    cnt_val  = DLY_W'(ABORT_CYC - 1);
                end else if (cnt_zero) begin
                    state_d = ST_XFER;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_XFER: begin
                if (start_rise) begin
                    if (xfer_done) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_ABORT;
                        cnt_load = 1'b1;
                        cnt_val  = DLY_W'(ABORT_CYC - 1);
                    end
                end else if (sclk_fall && !xfer_done) begin
                    sh_shift = 1'b1;
                end
            end
            ST_ABORT: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_dec = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Cycle registers: latched channel and falling-edge count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q     <= 1'b0;
            fall_cnt_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_fall) chan_q <= chan_s;
            if (sh_load)       fall_cnt_q <= '0;
            else if (sh_shift) fall_cnt_q <= fall_cnt_q + FC_W'(1);
        end
    end

    // Outputs
    always_comb begin
        sdat_oe = 1'b1;
        sdat_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   sdat_oe = 1'b0;
            ST_BUSY,
            ST_SETTLE,
            ST_ABORT:  sdat_o  = 1'b0;
            ST_XFER:   sdat_o  = sh_msb;
            default:   sdat_oe = 1'b0;
        endcase
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_fall) |=> (sdat_oe && !sdat_o)); // R2

    AST_READY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_XFER) |-> (sdat_oe && sdat_o)); // R6

    AST_FALLS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt_q <= FC_W'(XW)); // R7

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && start_rise && xfer_done) |=> !sdat_oe); // R8

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && start_rise && !xfer_done) |=> sdat_oe); // R9

    AST_BUSY_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !res_vld && !start_rise) |=> (state_q == ST_BUSY)); // R10

endmodule

// File: tb/cvt_readout_tb.sv
module cvt_readout_tb_top;

    localparam int RES_W = 15;
    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_n = 1'b1;
    logic             sclk = 1'b0;
    logic             chan_sel = 1'b0;
    logic [DLY_W-1:0] dly_cfg = '0;
    logic             res_vld = 1'b0;
    logic [RES_W-1:0] res_ch1 = '0;
    logic [RES_W-1:0] res_ch2 = '0;
    logic             sdat_o, sdat_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    cvt_readout #(.RES_W(RES_W), .DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .sclk(sclk),
        .chan_sel(chan_sel), .dly_cfg(dly_cfg), .res_vld(res_vld),
        .res_ch1(res_ch1), .res_ch2(res_ch2),
        .sdat_o(sdat_o), .sdat_oe(sdat_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input bit ch);
        @(negedge clk);
        chan_sel = ch;
        start_n  = 1'b0;
        wait_neg(6);
        chk(sdat_oe && !sdat_o, "R2 busy after start", {sdat_oe, sdat_o}, 2'b10);
    endtask

    task automatic sclk_pulses(input int np, inout logic [15:0] w);
        for (int i = 0; i < np; i++) begin
            w = {w[14:0], sdat_o};
            sclk = 1'b1;
            wait_neg(6);
            sclk = 1'b0;
            wait_neg(6);
        end
    endtask

    task automatic give_result(input logic [RES_W-1:0] r1, input logic [RES_W-1:0] r2, input int dly);
        int n;
        res_ch1 = r1;
        res_ch2 = r2;
        @(negedge clk);
        res_vld = 1'b1;
        @(posedge clk);
        n = 1;
        #1 res_vld = 1'b0;
        while (!sdat_o && n < 40) begin
            @(posedge clk);
            n++;
            #1;
        end
        chk(n == dly + 1, "R5 busy-to-ready edges", n, dly + 1);
    endtask

    task automatic finish_cycle(input bit expect_abort, input string req);
        @(negedge clk);
        start_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk(sdat_oe == expect_abort, req, sdat_oe, expect_abort);
        if (expect_abort) begin
            repeat (2) @(posedge clk);
            #1 chk(sdat_oe == 1'b1, "R9 still driven on third abort cycle", sdat_oe, 1);
            @(posedge clk);
            #1 chk(sdat_oe == 1'b0, "R9 released after three cycles", sdat_oe, 0);
        end
        wait_neg(4);
    endtask

    task automatic full_cycle(input bit ch, input int dly, input logic [RES_W-1:0] r1, input logic [RES_W-1:0] r2);
        logic [15:0]      w;
        logic [RES_W-1:0] exp;
        w = '0;
        exp = ch ? r2 : r1;
        dly_cfg = DLY_W'(dly);
        do_start(ch);
        give_result(r1, r2, dly);
        sclk_pulses(16, w);
        chk(w[15] == 1'b1, "R6 ready marker first", w[15], 1);
        chk(w[14:0] == exp, "R7 R3 data word", w[14:0], exp);
        finish_cycle(1'b0, "R8 release after full transfer");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0]      w;
        logic [RES_W-1:0] a, b;
        wait_neg(4);
        chk(sdat_oe == 1'b0, "R1 released in reset", sdat_oe, 0);
        rst_n = 1'b1;
        wait_neg(4);
        chk(sdat_oe == 1'b0, "R1 released after reset", sdat_oe, 0);

        // Sweep of delay, channel and data patterns
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 4; k++) begin
                    case (k)
                        0: a = 15'h0000;
                        1: a = 15'h7FFF;
                        2: a = 15'h5555;
                        default: a = RES_W'((d * 4679 + c * 911 + 12345) & 16'h7FFF);
                    endcase
                    b = ~a;
                    full_cycle(c[0], d, a, b);
                end
            end
        end

        // R3: flip chan_sel after the start edge
        w = '0;
        dly_cfg = 4'd1;
        do_start(1'b0);
        chan_sel = 1'b1;
        wait_neg(6);
        give_result(15'h1234, 15'h6ABC, 1);
        sclk_pulses(16, w);
        chk(w[14:0] == 15'h1234, "R3 late channel change ignored", w[14:0], 15'h1234);
        finish_cycle(1'b0, "R8 release after full transfer");

        // R10: sclk pulses while busy do not shift
        w = '0;
        dly_cfg = 4'd2;
        do_start(1'b1);
        sclk_pulses(3, w);
        w = '0;
        give_result(15'h0F0F, 15'h3C5A, 2);
        sclk_pulses(16, w);
        chk(w == {1'b1, 15'h3C5A}, "R10 busy sclk edges ignored", w, {1'b1, 15'h3C5A});
        finish_cycle(1'b0, "R8 release after full transfer");

        // R4: a result strobe mid-transfer leaves the word intact
        w = '0;
        dly_cfg = 4'd0;
        do_start(1'b0);
        give_result(15'h4321, 15'h0001, 0);
        sclk_pulses(4, w);
        res_ch1 = 15'h7777;
        @(negedge clk);
        res_vld = 1'b1;
        @(negedge clk);
        res_vld = 1'b0;
        sclk_pulses(12, w);
        chk(w == {1'b1, 15'h4321}, "R4 late strobe ignored", w, {1'b1, 15'h4321});
        // R7: extra falling edges beyond sixteen do not disturb the line
        sclk_pulses(2, w);
        chk(sdat_oe == 1'b1, "R7 extra edges keep line driven", sdat_oe, 1);
        finish_cycle(1'b0, "R8 release after extra edges");

        // R9: abort while busy
        dly_cfg = 4'd3;
        do_start(1'b0);
        finish_cycle(1'b1, "R9 abort from busy still driven");

        // R9: abort mid-transfer, partial bits are correct
        w = '0;
        dly_cfg = 4'd1;
        do_start(1'b1);
        give_result(15'h0000, 15'h6DB6, 1);
        sclk_pulses(5, w);
        chk(w[4:0] == {1'b1, 4'hD}, "R7 partial leading bits", w[4:0], {1'b1, 4'hD});
        finish_cycle(1'b1, "R9 abort from transfer still driven");

        // Recovery after an abort
        full_cycle(1'b0, 2, 15'h2AAA, 15'h1111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule